// File: doc/BRIEF.md
# Keypad Matrix Scanner

This block watches a five-column by four-row key matrix whose row lines have pull-ups. While idle it drives every column low, so that any pressed key pulls its row low. When a row falls, the block waits until the press has stayed down for a programmed number of millisecond ticks. It then raises a one-cycle interrupt and runs a scan.

The scan first drives all columns high. It then drives one column low at a time, in ascending order, and releases the other columns as inputs. A low row while a column is driven low locates the pressed key. The block reports a key code with a one-cycle valid strobe. It then drives all columns low again and waits for the key to be released before it arms itself for the next press.

If the scan finds no low row, the event is treated as a glitch and dropped. Row inputs pass through a two-flop synchronizer. Each scan step holds its column drive for a fixed settle window before the rows are sampled.

Top module: `kps_scanner`

## Requirements
- R1: After reset, and whenever the block is idle or waiting for release, every column has its output enable at 1 and its drive value at 0, and `key_valid` and `key_irq` are low.
- R2: A scan starts only after at least one row has stayed low for `deb_ticks` ticks of TICK_CYC clocks each. A value of 0 acts as 1. A press that ends earlier produces no interrupt and no code.
- R3: `key_irq` is a one-cycle pulse issued when a debounced press starts a scan.
- R4: Before the first column is driven low, all columns are driven high with output enable 1 for SETTLE cycles.
- R5: During the scan, exactly one column has its output enable at 1 and drives 0, and all other enables are 0. Columns are visited 0, 1, 2, 3, 4, and each is held for exactly SETTLE cycles.
- R6: A found key is reported as `key_code = column*4 + row` (0 to 19), where row 0 is `rows_in[0]` and column 0 is `col_out[0]`. `key_valid` is high for exactly one cycle.
- R7: When several keys are pressed, the lowest column that has a low row wins, and within that column the lowest row wins.
- R8: If no row is low in any column step, no code is reported and the block returns to idle.
- R9: After a report, all columns are driven low, and no further report occurs until all rows read high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rows_in | input | NROW | Raw row levels, high when no key |
| deb_ticks | input | DBW | Debounce length in ticks |
| col_out | output | NCOL | Column drive values |
| col_oe | output | NCOL | Column output enables, 1 = driven |
| key_code | output | $clog2(NCOL*NROW) | Code of the reported key |
| key_valid | output | 1 | One-cycle strobe for `key_code` |
| key_irq | output | 1 | One-cycle press interrupt |

## Verification
Assertions check four things on every cycle: that a scan step drives exactly one column low, that the interrupt and the valid strobe last one cycle and occur only in their matching states, that codes stay in range, and that the release wait never reports again. Other behaviour shows only in the bench scenarios: the debounce threshold against short presses, the precharge, the column order and the settle length seen at the pins, the priority when several keys are held, and the drop of a press that disappears during the scan. The bench uses a matrix model that pulls rows low through the driven columns.

// File: rtl/kps_pkg.sv
package kps_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEB  = 3'd1,
    ST_PRE  = 3'd2,
    ST_SCAN = 3'd3,
    ST_HOLD = 3'd4
  } kps_state_e;
endpackage

// File: rtl/kps_sync.sv
module kps_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b1;
        sync_q[i] <= 1'b1;
      end else begin
        meta_q[i] <= d[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/kps_tick.sv
module kps_tick #(
  parameter int TICK_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICK_CYC - 1);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_n;

  assign tick = !clr && (cnt_q == LAST);

  always_comb begin
    if (clr || tick) cnt_n = '0;
    else             cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/kps_ctrl.sv
module kps_ctrl
  import kps_pkg::*;
#(
  parameter int NCOL   = 5,
  parameter int NROW   = 4,
  parameter int SETTLE = 4,
  parameter int DBW    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NROW-1:0]               rows_s,
  input  logic                          tick,
  input  logic [DBW-1:0]                deb_ticks,
  output logic                          tick_clr,
  output logic [NCOL-1:0]               col_out,
  output logic [NCOL-1:0]               col_oe,
  output logic [$clog2(NCOL*NROW)-1:0]  key_code,
  output logic                          key_valid,
  output logic                          key_irq
);
  localparam int CODEW = $clog2(NCOL*NROW);
  localparam int CW    = (NCOL > 1) ? $clog2(NCOL) : 1;
  localparam int RW    = (NROW > 1) ? $clog2(NROW) : 1;
  localparam int SW    = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [SW-1:0] SET_LAST = SW'(SETTLE - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(NCOL - 1);

  kps_state_e       state_q, state_n;
  logic [CW-1:0]    col_q, col_n;
  logic [SW-1:0]    set_q, set_n;
  logic [DBW-1:0]   deb_q, deb_n;
  logic [CODEW-1:0] code_q, code_n;
  logic             valid_q, valid_n;
  logic             irq_q, irq_n;

  logic             any_low;
  logic [RW-1:0]    hit_row;
  logic             settle_done;
  logic             deb_done;

  assign any_low     = ~&rows_s;
  assign settle_done = (set_q == SET_LAST);
  assign deb_done    = ({1'b0, deb_q} + 1'b1) >= {1'b0, deb_ticks};

  always_comb begin
    hit_row = '0;
    for (int i = NROW - 1; i >= 0; i--) begin
      if (!rows_s[i]) hit_row = RW'(i);
    end
  end

  // next-state process
  always_comb begin
    state_n = state_q;
    col_n   = col_q;
    set_n   = set_q;
    deb_n   = deb_q;
    code_n  = code_q;
    valid_n = 1'b0;
    irq_n   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (any_low) begin
          state_n = ST_DEB;
          deb_n   = '0;
        end
      end
      ST_DEB: begin
        if (!any_low) begin
          state_n = ST_IDLE;
        end else if (tick) begin
          if (deb_done) begin
            state_n = ST_PRE;
            set_n   = '0;
            irq_n   = 1'b1;
          end else begin
            deb_n = deb_q + 1'b1;
          end
        end
      end
      ST_PRE: begin
        if (settle_done) begin
          state_n = ST_SCAN;
          col_n   = '0;
          set_n   = '0;
        end else begin
          set_n = set_q + 1'b1;
        end
      end
      ST_SCAN: begin
        if (settle_done) begin
          set_n = '0;
          if (any_low) begin
            state_n = ST_HOLD;
            code_n  = CODEW'(col_q) * CODEW'(NROW) + CODEW'(hit_row);
            valid_n = 1'b1;
          end else if (col_q == COL_LAST) begin
            state_n = ST_IDLE;
          end else begin
            col_n = col_q + 1'b1;
          end
        end else begin
          set_n = set_q + 1'b1;
        end
      end
      ST_HOLD: begin
        if (!any_low) state_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      set_q   <= '0;
      deb_q   <= '0;
      code_q  <= '0;
      valid_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      col_q   <= col_n;
      set_q   <= set_n;
      deb_q   <= deb_n;
      code_q  <= code_n;
      valid_q <= valid_n;
      irq_q   <= irq_n;
    end
  end

  // column drive decode
  always_comb begin
    col_oe  = '1;
    col_out = '0;
    if (state_q == ST_PRE) begin
      col_out = '1;
    end else if (state_q == ST_SCAN) begin
      for (int c = 0; c < NCOL; c++) begin
        col_oe[c]  = (col_q == CW'(c));
        col_out[c] = (col_q != CW'(c));
      end
    end
  end

  assign tick_clr  = (state_q != ST_DEB);
  assign key_code  = code_q;
  assign key_valid = valid_q;
  assign key_irq   = irq_q;

  AST_SCAN_ONE_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN) |-> ($countones(col_oe) == 1 && (col_oe & col_out) == '0)); // R5
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    key_irq |=> !key_irq); // R3
  AST_IRQ_STARTS_SCAN: assert property (@(posedge clk) disable iff (!rst_n)
    key_irq |-> (state_q == ST_PRE)); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid); // R6
  AST_VALID_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (state_q == ST_HOLD)); // R6
  AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> (int'(key_code) < NCOL*NROW)); // R6
  AST_HOLD_NO_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD && $past(state_q) == ST_HOLD) |-> !key_valid); // R9
endmodule

// File: rtl/kps_scanner.sv
module kps_scanner #(
  parameter int NCOL     = 5,
  parameter int NROW     = 4,
  parameter int TICK_CYC = 1000,
  parameter int SETTLE   = 4,
  parameter int DBW      = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NROW-1:0]               rows_in,
  input  logic [DBW-1:0]                deb_ticks,
  output logic [NCOL-1:0]               col_out,
  output logic [NCOL-1:0]               col_oe,
  output logic [$clog2(NCOL*NROW)-1:0]  key_code,
  output logic                          key_valid,
  output logic                          key_irq
);
  logic            rst_meta_q, rst_sync_q;
  logic [NROW-1:0] rows_s;
  logic            tick;
  logic            tick_clr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  kps_sync #(.W(NROW)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .d     (rows_in),
    .q     (rows_s)
  );

  kps_tick #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .clr   (tick_clr),
    .tick  (tick)
  );

  kps_ctrl #(
    .NCOL   (NCOL),
    .NROW   (NROW),
    .SETTLE (SETTLE),
    .DBW    (DBW)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .rows_s    (rows_s),
    .tick      (tick),
    .deb_ticks (deb_ticks),
    .tick_clr  (tick_clr),
    .col_out   (col_out),
    .col_oe    (col_oe),
    .key_code  (key_code),
    .key_valid (key_valid),
    .key_irq   (key_irq)
  );
endmodule

// File: tb/kps_scanner_bench.sv
module kps_scanner_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCOL   = 5;
  localparam int NROW   = 4;
  localparam int NK     = NCOL * NROW;
  localparam int TCYC   = 8;
  localparam int SETTLE = 4;
  localparam int DBW    = 8;

  logic            clk;
  logic            rst_n;
  logic [NROW-1:0] rows_in;
  logic [DBW-1:0]  deb_ticks;
  logic [NCOL-1:0] col_out, col_oe;
  logic [4:0]      key_code;
  logic            key_valid, key_irq;

  logic [NK-1:0]   keys;
  logic            noise;
  int checks, errors;
  int vcnt, icnt, lcode;
  bit running;

  kps_scanner #(.NCOL(NCOL), .NROW(NROW), .TICK_CYC(TCYC), .SETTLE(SETTLE), .DBW(DBW)) u_kps_scanner (
    .clk(clk), .rst_n(rst_n), .rows_in(rows_in), .deb_ticks(deb_ticks),
    .col_out(col_out), .col_oe(col_oe), .key_code(key_code),
    .key_valid(key_valid), .key_irq(key_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // matrix model: a key pulls its row low through a driven-low column
  always_comb begin
    rows_in = '1;
    for (int c = 0; c < NCOL; c++)
      for (int r = 0; r < NROW; r++)
        if (keys[c*NROW + r] && col_oe[c] && !col_out[c]) rows_in[r] = 1'b0;
    if (noise && (&col_oe) && col_out == '0) rows_in[0] = 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_code(input logic [NK-1:0] k);
    for (int i = 0; i < NK; i++) if (k[i]) return i;
    return -1;
  endfunction

  // output monitor
  logic [NCOL-1:0] prev_oe, prev_out;
  int run_len, prev_col;
  function automatic int col_of(input logic [NCOL-1:0] oe);
    for (int c = 0; c < NCOL; c++) if (oe[c]) return c;
    return -1;
  endfunction

  always @(negedge clk) begin
    if (running) begin
      if (key_valid) begin vcnt++; lcode = int'(key_code); end
      if (key_irq) icnt++;
      if (col_oe != '1) begin
        if (prev_oe != col_oe) begin
          chk($countones(col_oe) == 1 && (col_out & col_oe) == '0, "R5 one column low",
              $countones(col_oe), 1);
          if (prev_oe == '1) begin
            chk(col_of(col_oe) == 0, "R5 scan starts at column 0", col_of(col_oe), 0);
            chk(prev_out == '1, "R4 precharge before scan", int'(prev_out), (1 << NCOL) - 1);
          end else begin
            chk(col_of(col_oe) == prev_col + 1, "R5 ascending order", col_of(col_oe), prev_col + 1);
          end
        end
      end
      if (prev_oe != '1 && prev_oe != col_oe) begin
        chk(run_len == SETTLE, "R5 settle length", run_len, SETTLE);
      end
      run_len  = (col_oe == prev_oe) ? run_len + 1 : 1;
      prev_col = col_of(col_oe);
      prev_oe  = col_oe;
      prev_out = col_out;
    end
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
        finish_run();
      end
    end
  end

  task automatic idle_check(input string tag);
    chk(col_oe == '1 && col_out == '0, tag, int'({col_oe, col_out}), int'({5'h1f, 5'h00}));
  endtask

  task automatic press(input logic [NK-1:0] k, input int hold, input string tag);
    int exp;
    vcnt = 0; icnt = 0; lcode = -1;
    exp = exp_code(k);
    keys = k;
    repeat (hold) @(negedge clk);
    keys = '0;
    repeat (40) @(negedge clk);
    chk(icnt == 1, {tag, " irq count (R3)"}, icnt, 1);
    chk(vcnt == 1, {tag, " valid count (R6)"}, vcnt, 1);
    chk(lcode == exp, {tag, " key code"}, lcode, exp);
    idle_check("R1 columns low after release");
  endtask

  initial begin
    checks = 0; errors = 0; running = 0;
    keys = '0; noise = 1'b0; deb_ticks = 8'd3;
    vcnt = 0; icnt = 0; lcode = -1;
    prev_oe = '1; prev_out = '0; run_len = 0; prev_col = -1;
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    idle_check("R1 reset columns");
    chk(!key_valid && !key_irq, "R1 reset strobes", int'({key_valid, key_irq}), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    running = 1;
    idle_check("R1 idle columns");

    // every key alone
    for (int i = 0; i < NK; i++) begin
      logic [NK-1:0] k;
      k = '0; k[i] = 1'b1;
      press(k, 120, "R6 single key");
    end

    // priority
    press(NK'((1 << (2*NROW + 3)) | (1 << (2*NROW + 1))), 120, "R7 same column rows 1,3");
    press(NK'((1 << (4*NROW + 0)) | (1 << (1*NROW + 2))), 120, "R7 columns 1 and 4");

    // short press below debounce
    vcnt = 0; icnt = 0;
    keys = NK'(1 << 5);
    repeat (12) @(negedge clk);
    keys = '0;
    repeat (60) @(negedge clk);
    chk(icnt == 0, "R2 short press no irq", icnt, 0);
    chk(vcnt == 0, "R2 short press no code", vcnt, 0);

    // idle-only disturbance that vanishes during the scan
    vcnt = 0; icnt = 0;
    noise = 1'b1;
    while (icnt == 0) @(negedge clk);
    noise = 1'b0;
    repeat (60) @(negedge clk);
    chk(icnt == 1, "R8 glitch irq", icnt, 1);
    chk(vcnt == 0, "R8 glitch dropped", vcnt, 0);
    idle_check("R8 back to idle");

    // long hold: one report, columns low while held
    vcnt = 0; icnt = 0;
    keys = NK'(1 << 13);
    while (vcnt == 0) @(negedge clk);
    repeat (300) @(negedge clk);
    idle_check("R9 columns low while held");
    chk(vcnt == 1, "R9 single report while held", vcnt, 1);
    keys = '0;
    repeat (40) @(negedge clk);
    chk(vcnt == 1 && lcode == 13, "R9 code after hold", lcode, 13);

    // zero debounce acts as one tick
    deb_ticks = 8'd0;
    press(NK'(1 << 7), 80, "R2 zero debounce");
    deb_ticks = 8'd3;

    // random combinations
    for (int n = 0; n < 16; n++) begin
      logic [NK-1:0] k;
      k = '0;
      k[$urandom_range(NK-1, 0)] = 1'b1;
      if ($urandom_range(1, 0) == 1) k[$urandom_range(NK-1, 0)] = 1'b1;
      press(k, 100 + $urandom_range(60, 0), "R7 random keys");
    end

    finish_run();
  end
endmodule